// File: doc/BRIEF.md
# Binary Midpoint Vote Histogram Accumulator

This block turns a binary edge image into a one-dimensional histogram of horizontal centre candidates. Pixels enter one per accepted clock in raster order. For each column index of the line the block counts the edge pixel pairs on that line whose midpoint falls on that column, with the pair separation limited to a maximum circle diameter. A short window of single-bit flip-flops holds the most recent pixels of the line. AND/OR logic turns that window into a small vote increment for one bin. A read-modify-write path then adds the increment into a dual-port bin memory. Each accepted pixel finalises at most one bin, and no column FIFOs or wide adders are needed.

A frame is a fixed number of lines. A start-of-line marker goes with the first pixel of each line, and a start-of-frame marker also goes with the first pixel of the frame. After the last pixel of a line the block runs a short flush, one cycle per half diameter, to finalise the bins near the right edge. After the last line of the frame has flushed, the block streams every bin out in ascending column order and then pulses a completion flag. A downstream peak search takes the bins from this stream.

Top module: `midvote_hist`

## Requirements
- R1: After reset, `bin_valid_o` and `done_o` stay low, and they stay low until a full frame has been accepted.
- R2: With half diameter K = DM/2 and I(c) the edge bit at column c of a line (columns numbered 1..W), bin n gains on that line the number of offsets d in 1..K for which I(n-d) AND (I(n+d-1) OR I(n+d)) is 1.
- R3: A column below 1 or above W reads as 0. A pair never combines pixels from two different lines, including the last pixels of one line and the first pixels of the next.
- R4: Each offset adds at most one vote. When both I(n+d-1) and I(n+d) are set together with I(n-d), the bin gains 1 for that offset, not 2.
- R5: Votes add up over all H lines of the frame. A bin can reach H*K, and that value is reported without wrapping.
- R6: A first pixel that carries both the start-of-frame and the start-of-line markers clears every bin, so no vote from an earlier frame appears in the next readout.
- R7: A cycle with `pix_valid_i` low inside a line stalls the block. Inserting such gaps does not change any bin.
- R8: After the flush of line H, the W bins come out on consecutive cycles with `bin_valid_o` high and `bin_idx_o` counting 1, 2, ... W. `done_o` is high for exactly the one cycle after the bin with index W.
- R9: After the W-th pixel of a line, `pix_valid_i` must stay low for K cycles. A start-of-line pixel may follow on the next cycle, and bins computed with this minimum gap are exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_valid_i | input | 1 | A pixel is presented this cycle |
| pix_data_i | input | 1 | Edge bit of the presented pixel |
| pix_sol_i | input | 1 | Presented pixel is column 1 of a line |
| pix_sof_i | input | 1 | Presented pixel is column 1 of line 1 of a frame (sent together with pix_sol_i) |
| bin_valid_o | output | 1 | A finished bin is on bin_idx_o and bin_count_o |
| bin_idx_o | output | AW | Column index of the bin, 1..W |
| bin_count_o | output | CNT_W | Accumulated vote count of the bin |
| done_o | output | 1 | One-cycle pulse after the last bin of the readout |

## Verification
The hardest case to reach is the right edge of a line. Bins there are finalised only during the flush cycles after the last pixel, and their window overlaps the start of the next line when that line begins as early as the rules allow. The stimulus places edge pixels in the first two and last two columns and follows every line with the minimum idle gap, so any flush that is too short or any leak between lines moves a bin count. Other frames use only ones, only zeros, an all-zero frame right after an all-ones frame, tight runs of adjacent pixels, and random images with and without stall cycles. Every bin is compared against an arithmetic count of the stored image.

// File: rtl/mv_pkg.sv
package mv_pkg;

  // Half the maximum pair span; bins lag the newest pixel by this many columns.
  function automatic int mv_half(input int dm);
    return dm / 2;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int mv_bits(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

endpackage

// File: rtl/mv_shift_window.sv
module mv_shift_window #(
  parameter int DM = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        shift_i,
  input  logic        restart_i,
  input  logic        bit_i,
  output logic [DM:0] win_o
);

  logic [DM:0] win_q, win_d;

  // Bit 0 holds the newest column. A restart clears older columns to zero.
  always_comb begin
    win_d = win_q;
    if (shift_i) begin
      if (restart_i) win_d = {{DM{1'b0}}, bit_i};
      else           win_d = {win_q[DM-1:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= '0;
    else         win_q <= win_d;
  end

  assign win_o = win_q;

endmodule

// File: rtl/mv_pair_count.sv
module mv_pair_count #(
  parameter int DM = 8,
  parameter int IW = 3
) (
  input  logic [DM:0]   win_i,
  output logic [IW-1:0] inc_o
);

  localparam int HALF = mv_pkg::mv_half(DM);

  logic [HALF-1:0] hit;

  // Offset d pairs the left pixel (bin - d) with either of the two right
  // pixels (bin + d - 1, bin + d). An OR replaces their sum.
  for (genvar d = 1; d <= HALF; d++) begin : g_pair
    assign hit[d-1] = win_i[HALF+d] & (win_i[HALF-d+1] | win_i[HALF-d]);
  end

  always_comb begin
    inc_o = '0;
    for (int i = 0; i < HALF; i++) inc_o = inc_o + IW'(hit[i]);
  end

endmodule

// File: rtl/mv_bin_store.sv
module mv_bin_store #(
  parameter int W     = 32,
  parameter int AW    = 6,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i
);

  localparam int IXW = $clog2(W);

  logic [CNT_W-1:0] mem [W];
  logic [CNT_W-1:0] mem_rq;
  logic [W-1:0]     touched_q;
  logic             touched_rq;
  logic [IXW-1:0]   widx, ridx;

  assign widx = IXW'(wr_addr_i - AW'(1));
  assign ridx = IXW'(rd_addr_i - AW'(1));

  // Read returns the contents before a same-cycle write.
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[widx] <= wr_data_i;
    mem_rq <= mem[ridx];
  end

  // One flag per bin replaces a clearing sweep of the memory.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      touched_q  <= '0;
      touched_rq <= 1'b0;
    end else begin
      if (clr_i)        touched_q       <= '0;
      else if (wr_en_i) touched_q[widx] <= 1'b1;
      touched_rq <= touched_q[ridx];
    end
  end

  assign rd_data_o = touched_rq ? mem_rq : '0;

  AST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !wr_en_i); // R6

endmodule

// File: rtl/midvote_hist.sv
module midvote_hist #(
  parameter  int W     = 32,
  parameter  int DM    = 8,
  parameter  int H     = 4,
  localparam int AW    = $clog2(W + 1),
  localparam int CNT_W = $clog2(H * (DM / 2) + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_valid_i,
  input  logic             pix_data_i,
  input  logic             pix_sol_i,
  input  logic             pix_sof_i,
  output logic             bin_valid_o,
  output logic [AW-1:0]    bin_idx_o,
  output logic [CNT_W-1:0] bin_count_o,
  output logic             done_o
);

  localparam int HALF = mv_pkg::mv_half(DM);
  localparam int CW   = $clog2(W + HALF + 1);
  localparam int IW   = mv_pkg::mv_bits(HALF);
  localparam int LW   = mv_pkg::mv_bits(H);
  localparam logic [CW-1:0] W_C    = CW'(W);
  localparam logic [CW-1:0] WH_C   = CW'(W + HALF);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [AW-1:0] WA_C   = AW'(W);
  localparam logic [LW-1:0] LAST_L = LW'(H - 1);

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  // Line and frame control
  logic [CW-1:0] col_q, col_d;
  logic [LW-1:0] lines_q, lines_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          act_q, act_d, ro_q, ro_d, step_q, step_d;
  logic          flush, line_end, accept, restart, shift_en;

  always_comb begin
    flush    = act_q && (col_q >= W_C) && (col_q < WH_C);
    line_end = act_q && (col_q == WH_C);
    accept   = pix_valid_i && !ro_q && !flush &&
               (pix_sol_i || (act_q && (col_q < W_C)));
    restart  = accept && pix_sol_i;
    shift_en = accept || flush;

    col_d   = col_q;
    act_d   = act_q;
    lines_d = lines_q;
    ro_d    = ro_q;
    ptr_d   = ptr_q;
    step_d  = shift_en;
    if (line_end) begin
      act_d = 1'b0;
      if (lines_q == LAST_L) begin
        lines_d = '0;
        ro_d    = 1'b1;
        ptr_d   = AW'(1);
      end else begin
        lines_d = lines_q + LW'(1);
      end
    end
    if (ro_q) begin
      if (ptr_q == WA_C) ro_d  = 1'b0;
      else               ptr_d = ptr_q + AW'(1);
    end
    if (restart) begin
      col_d = CW'(1);
      act_d = 1'b1;
      if (pix_sof_i) lines_d = '0;
    end else if (shift_en) begin
      col_d = col_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      lines_q <= '0;
      ptr_q   <= '0;
      act_q   <= 1'b0;
      ro_q    <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      col_q   <= col_d;
      lines_q <= lines_d;
      ptr_q   <= ptr_d;
      act_q   <= act_d;
      ro_q    <= ro_d;
      step_q  <= step_d;
    end
  end

  // Pixel window and vote increment (stage 0)
  logic [DM:0]   win;
  logic [IW-1:0] inc;
  logic          bin_v;
  logic [AW-1:0] bin_addr, rd_addr;

  mv_shift_window #(.DM(DM)) u_window (
    .clk_i(clk_i), .rst_ni(rst_n), .shift_i(shift_en), .restart_i(restart),
    .bit_i(accept ? pix_data_i : 1'b0), .win_o(win)
  );

  mv_pair_count #(.DM(DM), .IW(IW)) u_pairs (.win_i(win), .inc_o(inc));

  assign bin_v    = step_q && (col_q > HALF_C);
  assign bin_addr = AW'(col_q - HALF_C);
  assign rd_addr  = ro_q ? ptr_q : bin_addr;

  // Read-modify-write (stage 1) with forwarding of the previous write
  logic             s1_v_q, lw_v_q;
  logic [AW-1:0]    s1_addr_q, lw_addr_q;
  logic [IW-1:0]    s1_inc_q;
  logic [CNT_W-1:0] lw_data_q, rd_data, base, sum;

  always_comb begin
    base = (lw_v_q && (lw_addr_q == s1_addr_q)) ? lw_data_q : rd_data;
    sum  = base + CNT_W'(s1_inc_q);
  end

  mv_bin_store #(.W(W), .AW(AW), .CNT_W(CNT_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_n), .clr_i(restart && pix_sof_i),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(s1_v_q), .wr_addr_i(s1_addr_q), .wr_data_i(sum)
  );

  logic          ov_q, olast_q, done_q;
  logic [AW-1:0] oidx_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q    <= 1'b0;
      s1_addr_q <= '0;
      s1_inc_q  <= '0;
      lw_v_q    <= 1'b0;
      lw_addr_q <= '0;
      lw_data_q <= '0;
      ov_q      <= 1'b0;
      oidx_q    <= '0;
      olast_q   <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      s1_v_q <= bin_v;
      if (bin_v) begin
        s1_addr_q <= bin_addr;
        s1_inc_q  <= inc;
      end
      lw_v_q <= s1_v_q;
      if (s1_v_q) begin
        lw_addr_q <= s1_addr_q;
        lw_data_q <= sum;
      end
      ov_q    <= ro_q;
      olast_q <= ro_q && (ptr_q == WA_C);
      done_q  <= olast_q;
      if (ro_q) oidx_q <= ptr_q;
    end
  end

  assign bin_valid_o = ov_q;
  assign bin_idx_o   = oidx_q;
  assign bin_count_o = rd_data;
  assign done_o      = done_q;

  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (act_q && (col_q >= W_C) && (col_q < WH_C)) |-> !pix_valid_i); // R9
  AST_RO_ORDER: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bin_valid_o && $past(bin_valid_o)) |-> (bin_idx_o == $past(bin_idx_o) + AW'(1))); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> ($past(bin_valid_o) && ($past(bin_idx_o) == WA_C))); // R8
  AST_CNT_MAX: assert property (@(posedge clk_i) disable iff (!rst_n)
    bin_valid_o |-> (bin_count_o <= CNT_W'(H * HALF))); // R5

endmodule

// File: tb/midvote_hist_tb.sv
`timescale 1ns/1ps
module midvote_hist_tb;

  localparam int W     = 32;
  localparam int DM    = 8;
  localparam int H     = 4;
  localparam int HALF  = DM / 2;
  localparam int AW    = $clog2(W + 1);
  localparam int CNT_W = $clog2(H * HALF + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, pv, pd, psol, psof;
  logic             bin_valid, done;
  logic [AW-1:0]    bin_idx;
  logic [CNT_W-1:0] bin_count;

  midvote_hist #(.W(W), .DM(DM), .H(H)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_valid_i(pv), .pix_data_i(pd),
    .pix_sol_i(psol), .pix_sof_i(psof), .bin_valid_o(bin_valid),
    .bin_idx_o(bin_idx), .bin_count_o(bin_count), .done_o(done)
  );

  int vectors = 0;
  int fails   = 0;
  bit img [H][W+2];
  int expv [W+1];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int px(input int l, input int c);
    if (c < 1 || c > W) return 0;
    return int'(img[l][c]);
  endfunction

  function automatic void compute_exp();
    for (int n = 1; n <= W; n++) begin
      int s = 0;
      for (int l = 0; l < H; l++)
        for (int d = 1; d <= HALF; d++)
          s += px(l, n - d) & (px(l, n + d - 1) | px(l, n + d));
      expv[n] = s;
    end
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pv = 1'b0; pd = 1'b0; psol = 1'b0; psof = 1'b0;
    end
  endtask

  task automatic clear_img();
    for (int l = 0; l < H; l++)
      for (int c = 0; c < W + 2; c++) img[l][c] = 1'b0;
  endtask

  // Stall cycles appear before every third column when gaps is set.
  task automatic drive_frame(input bit gaps, input int tail);
    for (int l = 0; l < H; l++) begin
      for (int c = 1; c <= W; c++) begin
        if (gaps && (c % 3 == 0)) idle(1);
        @(negedge clk);
        pv = 1'b1; pd = img[l][c]; psol = (c == 1); psof = (l == 0 && c == 1);
      end
      if (l != H - 1) idle(tail);
    end
  endtask

  task automatic collect(input string req);
    int  seen = 0;
    bit  got_done = 1'b0;
    for (int cyc = 0; cyc < 4 * W + 50; cyc++) begin
      @(negedge clk);
      pv = 1'b0; pd = 1'b0; psol = 1'b0; psof = 1'b0;
      if (bin_valid) begin
        check(int'(bin_idx) == seen + 1, "R8", "bin index order", int'(bin_idx), seen + 1);
        if (int'(bin_idx) >= 1 && int'(bin_idx) <= W)
          check(int'(bin_count) == expv[bin_idx], req, "bin count", int'(bin_count), expv[bin_idx]);
        seen++;
      end
      if (done) begin
        check(!bin_valid, "R8", "done alone", int'(bin_valid), 0);
        check(seen == W, "R8", "bins before done", seen, W);
        got_done = 1'b1;
        break;
      end
    end
    check(got_done, "R8", "done pulse seen", int'(got_done), 1);
    idle(3);
  endtask

  task automatic run_frame(input string req, input bit gaps, input int tail);
    compute_exp();
    drive_frame(gaps, tail);
    collect(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pv = 1'b0; pd = 1'b0; psol = 1'b0; psof = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(6);
    // R1: quiet outputs after reset
    check(!bin_valid, "R1", "bin_valid after reset", int'(bin_valid), 0);
    check(!done, "R1", "done after reset", int'(done), 0);
    idle(20);
    check(!bin_valid && !done, "R1", "outputs idle", int'(bin_valid | done), 0);

    clear_img();
    run_frame("R2", 1'b0, HALF);

    for (int l = 0; l < H; l++)
      for (int c = 1; c <= W; c++) img[l][c] = 1'b1;
    run_frame("R5", 1'b0, HALF);

    clear_img();
    run_frame("R6", 1'b0, HALF);

    // Edge columns and pixels at the boundary between lines
    clear_img();
    img[0][1] = 1; img[0][2] = 1; img[0][W] = 1;
    img[1][1] = 1; img[1][W-1] = 1; img[1][W] = 1;
    img[2][1] = 1; img[2][W] = 1; img[2][W-2] = 1;
    img[3][1] = 1; img[3][3] = 1; img[3][W-3] = 1; img[3][W] = 1;
    run_frame("R3", 1'b0, HALF);
    run_frame("R9", 1'b0, HALF);

    // Tight runs where the OR drops a vote
    clear_img();
    img[0][10] = 1; img[0][11] = 1; img[0][12] = 1;
    img[1][10] = 1; img[1][11] = 1;
    for (int c = 8; c <= 16; c++) img[2][c] = 1'b1;
    img[3][20] = 1; img[3][24] = 1; img[3][25] = 1;
    run_frame("R4", 1'b0, HALF);

    for (int f = 0; f < 6; f++) begin
      for (int l = 0; l < H; l++)
        for (int c = 1; c <= W; c++) img[l][c] = ($urandom % 3) != 0;
      run_frame("R2", 1'b0, HALF + f);
    end

    for (int f = 0; f < 3; f++) begin
      for (int l = 0; l < H; l++)
        for (int c = 1; c <= W; c++) img[l][c] = ($urandom % 2) != 0;
      run_frame("R7", 1'b1, HALF);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule